// File: doc/BRIEF.md
# Bus Reset Transmit Guard

This block sits in a serial bus link controller and governs the asynchronous transmit path around bus reset events. While the bus reset indication is high, the asynchronous transmitter is held off. The receiver is left running, so the self-identification packets that follow the reset can still be taken in. When the PHY later reports the node's new physical ID, the low field of the node ID register is reloaded and a status flag records that the ID is valid again.

Hardware never turns the transmitter back on. Host software must first correct any queued packets and then write an explicit restart. Restart writes that arrive while the bus reset is still in progress are dropped. A sticky reset flag and a one-cycle interrupt pulse let software follow these events. The flag is cleared by writing 1 to it.

The host register interface is write-only. Each write carries a 2-bit address: 0 is the control register, 1 is the node register, 2 is the status register, and 3 is unused. All outputs are registered. An input sampled at a rising clock edge takes effect on the outputs right after that edge.

Top module: `link_reset_guard`

## Requirements
- R1: While `bus_rst_i` is high at a clock edge, `tx_en_o` is 0 after that edge.
- R2: `rx_en_o` is never changed by a bus reset. It changes only through a control write (address 0) accepted while `bus_rst_i` is low, which loads it from data bit 1.
- R3: A PHY strobe (`phy_id_vld_i`) sampled while `bus_rst_i` is low loads `node_id_o[5:0]` from `phy_id_i` on the next cycle and leaves bits [15:6] unchanged.
- R4: `tx_en_o` goes from 0 to 1 only on a control write (address 0) with data bit 0 set. A control write with bit 0 clear turns it off. No hardware event re-enables it.
- R5: A control write sampled while `bus_rst_i` is high is ignored in full, including a write in the same cycle as the reset's rising edge.
- R6: `stat_rst_o` is set on the cycle after a rising edge of `bus_rst_i`. It is cleared by a status write (address 2) with data bit 0 set. When both happen in the same cycle, the set wins. A status write with bit 0 clear has no effect.
- R7: `stat_id_vld_o` is cleared after a rising edge of `bus_rst_i` and set after an accepted PHY strobe. A strobe sampled while `bus_rst_i` is high is ignored: neither the node ID nor this flag changes.
- R8: `irq_o` is high for exactly one cycle after each rising edge of `bus_rst_i` and after each accepted PHY strobe. It is low otherwise.
- R9: A node write (address 1) loads the bus number `node_id_o[15:6]` from data bits [15:6] and ignores data bits [5:0]. Writes to address 3 change nothing.
- R10: After reset, `tx_en_o`=0, `rx_en_o`=1, `node_id_o`=16'hFFFF, both status flags are 0 and `irq_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rst_i | input | 1 | High while a serial bus reset is in progress |
| phy_id_vld_i | input | 1 | PHY strobe: new physical ID is present |
| phy_id_i | input | 6 | Physical ID reported by the PHY |
| host_wr_i | input | 1 | Host register write strobe |
| host_addr_i | input | 2 | Register select: 0 control, 1 node, 2 status |
| host_wdata_i | input | 16 | Host write data |
| tx_en_o | output | 1 | Asynchronous transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| node_id_o | output | 16 | Node ID: bus number [15:6], physical ID [5:0] |
| stat_rst_o | output | 1 | Sticky bus-reset-seen flag |
| stat_id_vld_o | output | 1 | Node ID valid since the last bus reset |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
Two pairs of events can land in the same cycle. The first pair is a host write to the status register that clears the sticky flag, arriving on the same edge as the rising edge of the bus reset. The second pair is a control restart write arriving on that same reset edge. The bench drives each pair together on a single clock edge and checks that the reset outcome wins: the sticky flag ends up set, and the transmitter ends up off with the receiver enable unchanged. Around these collisions, the bench sweeps every physical ID and every bus number and checks the node register against the value built from the two fields in the bench.

// File: rtl/lrg_pkg.sv
// Shared definitions for the bus reset transmit guard.
// Assumes a 2-bit host register address.
package lrg_pkg;
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_NODE = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } lrg_reg_e;

    localparam int CTRL_TX_BIT = 0;
    localparam int CTRL_RX_BIT = 1;
    localparam int STAT_RST_BIT = 0;
endpackage

// File: rtl/lrg_edge.sv
// Rising edge detector for a synchronous level input.
// Assumes the level is already in the clk domain.
module lrg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_q;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/lrg_txrx.sv
// Transmit and receive enable registers.
// The transmitter is forced off while a bus reset is held. Only a host write turns it back on.
// Assumes ctrl_wr_i is already gated off during bus reset.
module lrg_txrx (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rst_i,
    input  logic ctrl_wr_i,
    input  logic tx_bit_i,
    input  logic rx_bit_i,
    output logic tx_en_o,
    output logic rx_en_o
);
    // Transmit enable: reset forces off, host write sets or clears.
    always_ff @(posedge clk) begin
        if (!rst_n)         tx_en_o <= 1'b0;
        else if (bus_rst_i) tx_en_o <= 1'b0;
        else if (ctrl_wr_i) tx_en_o <= tx_bit_i;
    end

    // Receive enable: only host writes change it.
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_en_o <= 1'b1;
        else if (ctrl_wr_i) rx_en_o <= rx_bit_i;
    end
endmodule

// File: rtl/lrg_node.sv
// Node ID register made of a host-owned bus number field and a PHY-owned physical ID field.
// Assumes id_ld_i is already qualified against the bus reset.
module lrg_node #(
    parameter int BUS_W = 10,
    parameter int PHY_W = 6,
    localparam int NODE_W = BUS_W + PHY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [BUS_W-1:0]  bus_num_i,
    input  logic              id_ld_i,
    input  logic [PHY_W-1:0]  phy_id_i,
    output logic [NODE_W-1:0] node_id_o
);
    logic [BUS_W-1:0] bus_q;
    logic [PHY_W-1:0] phy_q;

    // Bus number: written by host only, kept across bus reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        bus_q <= '1;
        else if (bus_wr_i) bus_q <= bus_num_i;
    end

    // Physical ID: loaded from the PHY report.
    always_ff @(posedge clk) begin
        if (!rst_n)       phy_q <= '1;
        else if (id_ld_i) phy_q <= phy_id_i;
    end

    assign node_id_o = {bus_q, phy_q};
endmodule

// File: rtl/lrg_stat.sv
// Status flags and interrupt pulse.
// The set from a reset edge takes priority over a host write-1-to-clear in the same cycle.
// Assumes rise_i and id_ld_i are never high together (id_ld_i is gated by the reset level).
module lrg_stat (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic clr_i,
    input  logic id_ld_i,
    output logic stat_rst_o,
    output logic stat_id_vld_o,
    output logic irq_o
);
    // Sticky reset flag: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      stat_rst_o <= 1'b0;
        else if (rise_i) stat_rst_o <= 1'b1;
        else if (clr_i)  stat_rst_o <= 1'b0;
    end

    // ID-valid flag: cleared by reset edge, set by accepted PHY report.
    always_ff @(posedge clk) begin
        if (!rst_n)       stat_id_vld_o <= 1'b0;
        else if (rise_i)  stat_id_vld_o <= 1'b0;
        else if (id_ld_i) stat_id_vld_o <= 1'b1;
    end

    // Interrupt: one pulse per event.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= rise_i | id_ld_i;
    end
endmodule

// File: rtl/link_reset_guard.sv
// Top of the bus reset transmit guard.
// Decodes host writes, qualifies the PHY report and control writes against the bus reset,
// and connects the enable, node and status units.
// Assumes all inputs are synchronous to clk.
module link_reset_guard #(
    parameter int BUS_W = 10,
    parameter int PHY_W = 6,
    localparam int NODE_W = BUS_W + PHY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst_i,
    input  logic              phy_id_vld_i,
    input  logic [PHY_W-1:0]  phy_id_i,
    input  logic              host_wr_i,
    input  logic [1:0]        host_addr_i,
    input  logic [NODE_W-1:0] host_wdata_i,
    output logic              tx_en_o,
    output logic              rx_en_o,
    output logic [NODE_W-1:0] node_id_o,
    output logic              stat_rst_o,
    output logic              stat_id_vld_o,
    output logic              irq_o
);
    import lrg_pkg::*;

    lrg_reg_e reg_sel;
    logic     ctrl_wr;
    logic     node_wr;
    logic     stat_clr;
    logic     id_ld;
    logic     rst_rise;
    logic     unused_wdata;

    // Write decode: control writes are dropped while the reset is held.
    assign reg_sel  = lrg_reg_e'(host_addr_i);
    assign ctrl_wr  = host_wr_i && (reg_sel == REG_CTRL) && !bus_rst_i;
    assign node_wr  = host_wr_i && (reg_sel == REG_NODE);
    assign stat_clr = host_wr_i && (reg_sel == REG_STAT) && host_wdata_i[STAT_RST_BIT];
    assign id_ld    = phy_id_vld_i && !bus_rst_i;
    assign unused_wdata = ^host_wdata_i[PHY_W-1:2];

    lrg_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (bus_rst_i),
        .rise_o (rst_rise)
    );

    lrg_txrx u_txrx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rst_i (bus_rst_i),
        .ctrl_wr_i (ctrl_wr),
        .tx_bit_i  (host_wdata_i[CTRL_TX_BIT]),
        .rx_bit_i  (host_wdata_i[CTRL_RX_BIT]),
        .tx_en_o   (tx_en_o),
        .rx_en_o   (rx_en_o)
    );

    lrg_node #(.BUS_W(BUS_W), .PHY_W(PHY_W)) u_node (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_i  (node_wr),
        .bus_num_i (host_wdata_i[NODE_W-1:PHY_W]),
        .id_ld_i   (id_ld),
        .phy_id_i  (phy_id_i),
        .node_id_o (node_id_o)
    );

    lrg_stat u_stat (
        .clk           (clk),
        .rst_n         (rst_n),
        .rise_i        (rst_rise),
        .clr_i         (stat_clr),
        .id_ld_i       (id_ld),
        .stat_rst_o    (stat_rst_o),
        .stat_id_vld_o (stat_id_vld_o),
        .irq_o         (irq_o)
    );
endmodule

// File: rtl/lrg_chk.sv
// Property checker for link_reset_guard, attached by bind.
// Observes only the ports of the top module.
module lrg_chk #(
    parameter int BUS_W = 10,
    parameter int PHY_W = 6,
    localparam int NODE_W = BUS_W + PHY_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rst_i,
    input logic              phy_id_vld_i,
    input logic [PHY_W-1:0]  phy_id_i,
    input logic              host_wr_i,
    input logic [1:0]        host_addr_i,
    input logic [NODE_W-1:0] host_wdata_i,
    input logic              tx_en_o,
    input logic              rx_en_o,
    input logic [NODE_W-1:0] node_id_o,
    input logic              stat_rst_o,
    input logic              stat_id_vld_o,
    input logic              irq_o
);
    assert_tx_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_i |=> !tx_en_o);

    assert_rx_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_i |=> $stable(rx_en_o));

    assert_phy_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_id_vld_i && !bus_rst_i) |=> (node_id_o[PHY_W-1:0] == $past(phy_id_i)));

    assert_no_hw_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en_o && !(host_wr_i && host_addr_i == 2'd0 && host_wdata_i[0])) |=> !tx_en_o);

    assert_sticky_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rst_i) |=> stat_rst_o);

    assert_id_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rst_i) |=> !stat_id_vld_o);

    assert_irq_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rst_i) |=> irq_o);

    assert_bus_num_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_i && host_addr_i == 2'd1) |=>
            (node_id_o[NODE_W-1:PHY_W] == $past(host_wdata_i[NODE_W-1:PHY_W])));
endmodule

bind link_reset_guard lrg_chk #(.BUS_W(BUS_W), .PHY_W(PHY_W)) u_lrg_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_rst_i     (bus_rst_i),
    .phy_id_vld_i  (phy_id_vld_i),
    .phy_id_i      (phy_id_i),
    .host_wr_i     (host_wr_i),
    .host_addr_i   (host_addr_i),
    .host_wdata_i  (host_wdata_i),
    .tx_en_o       (tx_en_o),
    .rx_en_o       (rx_en_o),
    .node_id_o     (node_id_o),
    .stat_rst_o    (stat_rst_o),
    .stat_id_vld_o (stat_id_vld_o),
    .irq_o         (irq_o)
);

// File: tb/link_reset_guard_bench.sv
// Self-checking bench for link_reset_guard. Inputs change on the falling edge;
// outputs are checked on the falling edge after the rising edge that samples them.
module link_reset_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rst_i = 1'b0;
    logic        phy_id_vld_i = 1'b0;
    logic [5:0]  phy_id_i = '0;
    logic        host_wr_i = 1'b0;
    logic [1:0]  host_addr_i = '0;
    logic [15:0] host_wdata_i = '0;
    logic        tx_en_o, rx_en_o, stat_rst_o, stat_id_vld_o, irq_o;
    logic [15:0] node_id_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [9:0] bus_exp;

    always #5 clk = ~clk;

    link_reset_guard u_link_reset_guard (
        .clk(clk), .rst_n(rst_n), .bus_rst_i(bus_rst_i),
        .phy_id_vld_i(phy_id_vld_i), .phy_id_i(phy_id_i),
        .host_wr_i(host_wr_i), .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i),
        .tx_en_o(tx_en_o), .rx_en_o(rx_en_o), .node_id_o(node_id_o),
        .stat_rst_o(stat_rst_o), .stat_id_vld_o(stat_id_vld_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        host_wr_i = 1'b1; host_addr_i = a; host_wdata_i = d;
    endtask

    task automatic idle();
        host_wr_i = 1'b0; phy_id_vld_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk); cyc(); cyc();
        rst_n = 1'b1;
        // R10 reset state
        chk("R10 tx", tx_en_o, 0);
        chk("R10 rx", rx_en_o, 1);
        chk("R10 node", node_id_o, 16'hFFFF);
        chk("R10 stat_rst", stat_rst_o, 0);
        chk("R10 id_vld", stat_id_vld_o, 0);
        chk("R10 irq", irq_o, 0);

        // R4 host restart enables transmitter
        wr(2'd0, 16'h0003); cyc(); idle();
        chk("R4 restart", tx_en_o, 1);
        chk("R2 rx write", rx_en_o, 1);
        cyc(); cyc();
        chk("R4 holds", tx_en_o, 1);

        // R9 sweep all bus numbers, low data bits must be ignored
        for (int b = 0; b < 1024; b++) begin
            wr(2'd1, {b[9:0], 6'b101010}); cyc();
            chk("R9 bus num", node_id_o, {b[9:0], 6'h3F});
        end
        idle();
        bus_exp = 10'd1023;
        wr(2'd3, 16'h0000); cyc(); idle();
        chk("R9 addr3 node", node_id_o, {bus_exp, 6'h3F});
        chk("R9 addr3 tx", tx_en_o, 1);

        // R1 bus reset rising edge
        bus_rst_i = 1'b1; cyc();
        chk("R1 tx off", tx_en_o, 0);
        chk("R2 rx kept", rx_en_o, 1);
        chk("R6 sticky", stat_rst_o, 1);
        chk("R7 id clr", stat_id_vld_o, 0);
        chk("R8 irq edge", irq_o, 1);
        cyc();
        chk("R8 irq one cycle", irq_o, 0);

        // R5 restart during reset ignored; R7 strobe during reset ignored
        wr(2'd0, 16'h0001); cyc(); idle();
        chk("R5 ignored tx", tx_en_o, 0);
        chk("R5 ignored rx", rx_en_o, 1);
        phy_id_vld_i = 1'b1; phy_id_i = 6'd5; cyc(); idle();
        chk("R7 strobe ignored node", node_id_o, {bus_exp, 6'h3F});
        chk("R7 strobe ignored vld", stat_id_vld_o, 0);
        chk("R8 no irq", irq_o, 0);

        bus_rst_i = 1'b0; cyc();
        chk("R4 no hw reenable", tx_en_o, 0);

        // R3 sweep every physical ID
        for (int p = 0; p < 64; p++) begin
            phy_id_vld_i = 1'b1; phy_id_i = p[5:0]; cyc();
            chk("R3 node", node_id_o, {bus_exp, p[5:0]});
            chk("R7 id vld", stat_id_vld_o, 1);
            chk("R8 irq id", irq_o, 1);
            phy_id_vld_i = 1'b0; cyc();
            chk("R8 irq drop", irq_o, 0);
        end
        chk("R4 still off", tx_en_o, 0);

        // R6 write of 0 does not clear, write of 1 clears
        wr(2'd2, 16'h0000); cyc(); idle();
        chk("R6 w0", stat_rst_o, 1);
        wr(2'd2, 16'h0001); cyc(); idle();
        chk("R6 w1c", stat_rst_o, 0);

        // R2/R4 restart with rx off, then disable via write
        wr(2'd0, 16'h0001); cyc(); idle();
        chk("R4 restart2", tx_en_o, 1);
        chk("R2 rx off", rx_en_o, 0);

        // R5 collision: restart write on reset edge
        bus_rst_i = 1'b1; wr(2'd0, 16'h0003); cyc(); idle();
        chk("R5 collide tx", tx_en_o, 0);
        chk("R5 collide rx", rx_en_o, 0);
        bus_rst_i = 1'b0; cyc();

        // R6 collision: clear write on reset edge, set wins
        wr(2'd2, 16'h0001); cyc(); idle();
        chk("R6 cleared", stat_rst_o, 0);
        bus_rst_i = 1'b1; wr(2'd2, 16'h0001); cyc(); idle();
        chk("R6 set wins", stat_rst_o, 1);
        bus_rst_i = 1'b0; cyc();
        wr(2'd0, 16'h0000); cyc(); idle();
        chk("R4 write clears", tx_en_o, 0);

        finish_run();
    end
endmodule